// File: doc/BRIEF.md
# Card Reader/Punch Column Transfer Controller

This controller sits between a processor's I/O command path and a combined card reader and punch mechanism. It moves card images of up to 80 columns between the mechanism and a byte-wide memory port, one byte per column, without processor involvement. Software first loads a 16-bit memory address and a 16-bit byte count, then issues a start command naming one of five card operations and a stacker. The controller then steps through the card's columns. Each column is either written into memory or fetched from memory and handed to the punch.

One address register and one count register serve both directions. The address advances by one for every byte moved and is never put back, so software reloads it before each card. A card finishes when the mechanism reports it done and no memory request is still open. Status is read through a sense port and a test port that evaluates branch conditions. When no input deck is loaded but punch output is available, a read is still accepted and delivers blank columns. This lets blank stock be checked before punching.

Top module: `cardxfer_ctrl`

## Requirements
- R1: After reset `busy`, `mem_req` and `mech_go` are low, and a status sense (function 3) with a deck present and punch ready returns 0x0000.
- R2: A load with function 0 sets the byte count and a load with function 4 sets the memory address. Both take their value from `load_data`.
- R3: An accepted start raises `busy` and pulses `mech_go` for one cycle, one cycle after the command. The pulse carries `mech_func` equal to the start function and `mech_stacker` equal to bit 0 of `start_ctl` (0 normal, 1 second stacker).
- R4: On a read (function 1 or 3), each column byte inside the transfer window is written to memory at the current address. A memory request is held with a stable address until `mem_ack`.
- R5: The transfer window closes when the byte count reaches zero or 80 columns have passed, whichever comes first. A count of 0 moves nothing.
- R6: The address advances once per moved byte and keeps its value after the card. A following card without a reload continues at the next address.
- R7: On a punch (function 2, or function 4 without feed), bytes are fetched from memory in ascending address order. They are presented on `col_pdata` with `col_pvalid` high at successive column ticks, for the first min(count, 80) columns.
- R8: A read started with no deck present but punch ready is accepted, and every byte it writes is 0x40.
- R9: If a column arrives while the previous write is still unacknowledged, or a punch column tick finds no fetched byte while bytes remain, status bit 0x1000 (overrun) sets. It stays set until the next accepted start.
- R10: The status word uses 0x8000 read check, 0x4000 last card, 0x2000 punch check, 0x1000 overrun and 0x0800 not ready (no deck and no punch). The two check bits are sticky until the next accepted start.
- R11: Test function 0 is true when the device is not ready or busy. Test function 2 is true only when busy. Other test functions are false.
- R12: A start is ignored while busy, for functions 5 to 7, when not ready, for a punch without punch ready, and for a read with neither deck nor punch.
- R13: A feed (function 0) makes no memory request. `busy` falls after `mech_done` once no memory request is open, and no memory request is raised while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Start command strobe |
| start_func | input | 3 | Card operation code 0..4 |
| start_ctl | input | 8 | Control byte, bit 0 selects stacker |
| load_valid | input | 1 | Register load strobe |
| load_func | input | 3 | 0 loads byte count, 4 loads address |
| load_data | input | 16 | Load value |
| sense_func | input | 3 | Sense selector, 3 returns status |
| sense_word | output | 16 | Sensed value |
| test_func | input | 3 | Branch condition selector |
| test_hit | output | 1 | Branch condition true |
| busy | output | 1 | Card operation in progress |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| deck_present | input | 1 | Input deck loaded |
| punch_ready | input | 1 | Punch output available |
| last_card | input | 1 | Last card level from mechanism |
| mech_go | output | 1 | One-cycle start to mechanism |
| mech_func | output | 3 | Operation for mechanism |
| mech_stacker | output | 1 | Stacker choice for mechanism |
| col_tick | input | 1 | One pulse per card column |
| col_rdata | input | 8 | Column byte read by the mechanism |
| col_pdata | output | 8 | Column byte to punch |
| col_pvalid | output | 1 | col_pdata holds a fetched byte |
| mech_done | input | 1 | Card cycle finished |
| read_check | input | 1 | Read error pulse |
| punch_check | input | 1 | Punch error pulse |

## Verification
A wrong address or count register shows up at the memory port within one column. The first write or fetch lands at the wrong address, or the number of moved bytes differs from min(count, 80), and that is visible on the card in which the fault occurs. A stale address after a card shows up on the first request of the next unreloaded card. A lost overrun or check flag, or one cleared too early, shows up on the next status sense. A sequencer stuck busy shows up within a few cycles of `mech_done`, because test function 2 keeps reporting true and the next start is refused.

// File: rtl/cardxfer_pkg.sv
package cardxfer_pkg;
   localparam logic [2:0] FN_FEED       = 3'd0;
   localparam logic [2:0] FN_READ       = 3'd1;
   localparam logic [2:0] FN_PUNCH_FEED = 3'd2;
   localparam logic [2:0] FN_READ_BIN   = 3'd3;
   localparam logic [2:0] FN_PUNCH_HOLD = 3'd4;

   localparam logic [2:0] LD_COUNT = 3'd0;
   localparam logic [2:0] LD_ADDR  = 3'd4;

   localparam logic [2:0] SN_STATUS = 3'd3;

   localparam logic [2:0] TS_NRDY_BUSY = 3'd0;
   localparam logic [2:0] TS_BUSY      = 3'd2;

   localparam int ST_RDCHK = 15;
   localparam int ST_LAST  = 14;
   localparam int ST_PUCHK = 13;
   localparam int ST_OVR   = 12;
   localparam int ST_NRDY  = 11;

   typedef struct packed {
      logic rd_chk;
      logic pu_chk;
      logic ovr;
   } sticky_t;
endpackage

// File: rtl/cardxfer_regs.sv
module cardxfer_regs
   import cardxfer_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int LW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_valid,
   input  logic [2:0]    ld_func,
   input  logic [LW-1:0] ld_data,
   input  logic          advance,
   output logic [AW-1:0] dar,
   output logic          lcr_zero,
   output logic          lcr_one
);
   logic [CW-1:0] lcr;

   initial begin
      assert (AW <= LW && CW <= LW && AW > 0 && CW > 0)
         else $fatal(1, "register widths must fit the load word");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dar <= '0;
      end else if (ld_valid && ld_func == LD_ADDR) begin
         dar <= ld_data[AW-1:0];
      end else if (advance) begin
         dar <= dar + AW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcr <= '0;
      end else if (ld_valid && ld_func == LD_COUNT) begin
         lcr <= ld_data[CW-1:0];
      end else if (advance && lcr != '0) begin
         lcr <= lcr - CW'(1);
      end
   end

   assign lcr_zero = (lcr == '0);
   assign lcr_one  = (lcr == CW'(1));
endmodule

// File: rtl/cardxfer_seq.sv
module cardxfer_seq
   import cardxfer_pkg::*;
#(
   parameter int BLANK_SUPPLY = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_valid,
   input  logic [2:0] start_func,
   input  logic [7:0] start_ctl,
   input  logic       deck_present,
   input  logic       punch_ready,
   input  logic       mech_done,
   input  logic       mover_idle,
   output logic       busy,
   output logic       start_acc,
   output logic       winding,
   output logic       mech_go,
   output logic [2:0] mech_func,
   output logic       mech_stacker,
   output logic       dir_in,
   output logic       dir_out,
   output logic       blank_sub
);
   logic func_ok;
   logic is_read;
   logic is_punch;
   logic done_seen;
   logic blank_ok;

   generate
      if (BLANK_SUPPLY != 0) begin : g_blank_on
         assign blank_ok = punch_ready;
      end else begin : g_blank_off
         assign blank_ok = 1'b0;
      end
   endgenerate

   assign is_read  = (start_func == FN_READ) || (start_func == FN_READ_BIN);
   assign is_punch = (start_func == FN_PUNCH_FEED) || (start_func == FN_PUNCH_HOLD);

   always_comb begin
      case (start_func)
         FN_FEED:                    func_ok = deck_present | punch_ready;
         FN_READ, FN_READ_BIN:       func_ok = deck_present | blank_ok;
         FN_PUNCH_FEED, FN_PUNCH_HOLD: func_ok = punch_ready;
         default:                    func_ok = 1'b0;
      endcase
   end

   assign start_acc = start_valid && !busy && func_ok;
   assign winding   = busy && (done_seen || mech_done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy         <= 1'b0;
         done_seen    <= 1'b0;
         mech_go      <= 1'b0;
         mech_func    <= 3'd0;
         mech_stacker <= 1'b0;
         dir_in       <= 1'b0;
         dir_out      <= 1'b0;
         blank_sub    <= 1'b0;
      end else begin
         mech_go <= start_acc;
         if (start_acc) begin
            busy         <= 1'b1;
            done_seen    <= 1'b0;
            mech_func    <= start_func;
            mech_stacker <= start_ctl[0];
            dir_in       <= is_read;
            dir_out      <= is_punch;
            blank_sub    <= is_read && !deck_present;
         end else if (busy) begin
            if (mech_done) begin
               done_seen <= 1'b1;
            end
            if (winding && mover_idle) begin
               busy      <= 1'b0;
               done_seen <= 1'b0;
               dir_in    <= 1'b0;
               dir_out   <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/cardxfer_mover.sv
module cardxfer_mover
   import cardxfer_pkg::*;
#(
   parameter int         AW           = 16,
   parameter int         COLS         = 80,
   parameter logic [7:0] BLANK        = 8'h40,
   parameter int         BLANK_SUPPLY = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_acc,
   input  logic          winding,
   input  logic          dir_in,
   input  logic          dir_out,
   input  logic          blank_sub,
   input  logic [AW-1:0] dar,
   input  logic          lcr_zero,
   input  logic          lcr_one,
   input  logic          col_tick,
   input  logic [7:0]    col_rdata,
   input  logic          mem_ack,
   input  logic [7:0]    mem_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_wdata,
   output logic [7:0]    col_pdata,
   output logic          col_pvalid,
   output logic          advance,
   output logic          overrun_evt,
   output logic          idle
);
   localparam int CIW = $clog2(COLS + 1);

   initial begin
      assert (COLS > 0) else $fatal(1, "COLS must be positive");
   end

   logic [CIW-1:0] col_idx;
   logic [CIW-1:0] mv_cnt;
   logic [7:0]     buf_q;
   logic           buf_v;
   logic           req_q;
   logic           we_q;
   logic [7:0]     wdata_q;
   logic [7:0]     in_byte;

   logic col_open;
   logic rd_room;
   logic more_out;
   logic xfer_done;
   logic rd_take;
   logic rd_ovr;
   logic pu_tick;
   logic pu_ovr;
   logic fetch_go;

   generate
      if (BLANK_SUPPLY != 0) begin : g_sub
         assign in_byte = blank_sub ? BLANK : col_rdata;
      end else begin : g_nosub
         assign in_byte = col_rdata;
      end
   endgenerate

   assign col_open  = col_idx < CIW'(COLS);
   assign rd_room   = !lcr_zero && !(lcr_one && req_q);
   assign more_out  = (mv_cnt < CIW'(COLS)) && !lcr_zero;
   assign xfer_done = req_q && mem_ack;

   assign rd_take = dir_in && col_tick && col_open && rd_room && !winding;
   assign rd_ovr  = rd_take && req_q && !mem_ack;

   assign pu_tick  = dir_out && col_tick && col_open;
   assign pu_ovr   = pu_tick && !buf_v && more_out;
   assign fetch_go = dir_out && !buf_v && !req_q && col_open && more_out && !winding;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_idx <= '0;
         mv_cnt  <= '0;
         buf_q   <= 8'h00;
         buf_v   <= 1'b0;
         req_q   <= 1'b0;
         we_q    <= 1'b0;
         wdata_q <= 8'h00;
      end else if (start_acc) begin
         col_idx <= '0;
         mv_cnt  <= '0;
         buf_v   <= 1'b0;
      end else begin
         if ((dir_in || dir_out) && col_tick && col_open) begin
            col_idx <= col_idx + CIW'(1);
         end
         if (xfer_done) begin
            req_q  <= 1'b0;
            mv_cnt <= mv_cnt + CIW'(1);
            if (!we_q) begin
               buf_q <= mem_rdata;
               buf_v <= 1'b1;
            end
         end
         if (rd_take && !rd_ovr) begin
            req_q   <= 1'b1;
            we_q    <= 1'b1;
            wdata_q <= in_byte;
         end
         if (fetch_go) begin
            req_q <= 1'b1;
            we_q  <= 1'b0;
         end
         if (pu_tick && buf_v) begin
            buf_v <= 1'b0;
         end
      end
   end

   assign mem_req     = req_q;
   assign mem_we      = we_q;
   assign mem_addr    = dar;
   assign mem_wdata   = wdata_q;
   assign col_pvalid  = dir_out && buf_v;
   assign col_pdata   = col_pvalid ? buf_q : 8'h00;
   assign advance     = xfer_done;
   assign overrun_evt = rd_ovr || pu_ovr;
   assign idle        = !req_q;
endmodule

// File: rtl/cardxfer_status.sv
module cardxfer_status
   import cardxfer_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_acc,
   input  logic        read_check,
   input  logic        punch_check,
   input  logic        overrun_evt,
   input  logic        last_card,
   input  logic        not_ready,
   input  logic        busy,
   input  logic [2:0]  sense_func,
   input  logic [2:0]  test_func,
   output logic [15:0] sense_word,
   output logic        test_hit,
   output logic        ovr_sticky
);
   sticky_t st;
   logic [15:0] status;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= '0;
      end else begin
         if (start_acc) begin
            st <= '0;
         end
         if (read_check)  st.rd_chk <= 1'b1;
         if (punch_check) st.pu_chk <= 1'b1;
         if (overrun_evt) st.ovr    <= 1'b1;
      end
   end

   always_comb begin
      status           = 16'h0000;
      status[ST_RDCHK] = st.rd_chk;
      status[ST_LAST]  = last_card;
      status[ST_PUCHK] = st.pu_chk;
      status[ST_OVR]   = st.ovr;
      status[ST_NRDY]  = not_ready;
   end

   assign sense_word = (sense_func == SN_STATUS) ? status : 16'h0000;

   always_comb begin
      case (test_func)
         TS_NRDY_BUSY: test_hit = not_ready | busy;
         TS_BUSY:      test_hit = busy;
         default:      test_hit = 1'b0;
      endcase
   end

   assign ovr_sticky = st.ovr;
endmodule

// File: rtl/cardxfer_ctrl.sv
module cardxfer_ctrl
   import cardxfer_pkg::*;
#(
   parameter int         AW           = 16,
   parameter int         CW           = 16,
   parameter int         LW           = 16,
   parameter int         COLS         = 80,
   parameter logic [7:0] BLANK        = 8'h40,
   parameter int         BLANK_SUPPLY = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_valid,
   input  logic [2:0]    start_func,
   input  logic [7:0]    start_ctl,
   input  logic          load_valid,
   input  logic [2:0]    load_func,
   input  logic [LW-1:0] load_data,
   input  logic [2:0]    sense_func,
   output logic [15:0]   sense_word,
   input  logic [2:0]    test_func,
   output logic          test_hit,
   output logic          busy,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_wdata,
   input  logic          mem_ack,
   input  logic [7:0]    mem_rdata,
   input  logic          deck_present,
   input  logic          punch_ready,
   input  logic          last_card,
   output logic          mech_go,
   output logic [2:0]    mech_func,
   output logic          mech_stacker,
   input  logic          col_tick,
   input  logic [7:0]    col_rdata,
   output logic [7:0]    col_pdata,
   output logic          col_pvalid,
   input  logic          mech_done,
   input  logic          read_check,
   input  logic          punch_check
);
   logic          start_acc;
   logic          winding;
   logic          dir_in;
   logic          dir_out;
   logic          blank_sub;
   logic [AW-1:0] dar;
   logic          lcr_zero;
   logic          lcr_one;
   logic          advance;
   logic          overrun_evt;
   logic          mover_idle;
   logic          not_ready;
   logic          ovr_sticky;

   assign not_ready = !deck_present && !punch_ready;

   cardxfer_regs #(.AW(AW), .CW(CW), .LW(LW)) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_valid (load_valid),
      .ld_func  (load_func),
      .ld_data  (load_data),
      .advance  (advance),
      .dar      (dar),
      .lcr_zero (lcr_zero),
      .lcr_one  (lcr_one)
   );

   cardxfer_seq #(.BLANK_SUPPLY(BLANK_SUPPLY)) i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_valid  (start_valid),
      .start_func   (start_func),
      .start_ctl    (start_ctl),
      .deck_present (deck_present),
      .punch_ready  (punch_ready),
      .mech_done    (mech_done),
      .mover_idle   (mover_idle),
      .busy         (busy),
      .start_acc    (start_acc),
      .winding      (winding),
      .mech_go      (mech_go),
      .mech_func    (mech_func),
      .mech_stacker (mech_stacker),
      .dir_in       (dir_in),
      .dir_out      (dir_out),
      .blank_sub    (blank_sub)
   );

   cardxfer_mover #(.AW(AW), .COLS(COLS), .BLANK(BLANK), .BLANK_SUPPLY(BLANK_SUPPLY)) i_mover (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_acc   (start_acc),
      .winding     (winding),
      .dir_in      (dir_in),
      .dir_out     (dir_out),
      .blank_sub   (blank_sub),
      .dar         (dar),
      .lcr_zero    (lcr_zero),
      .lcr_one     (lcr_one),
      .col_tick    (col_tick),
      .col_rdata   (col_rdata),
      .mem_ack     (mem_ack),
      .mem_rdata   (mem_rdata),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .col_pdata   (col_pdata),
      .col_pvalid  (col_pvalid),
      .advance     (advance),
      .overrun_evt (overrun_evt),
      .idle        (mover_idle)
   );

   cardxfer_status i_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_acc   (start_acc),
      .read_check  (read_check),
      .punch_check (punch_check),
      .overrun_evt (overrun_evt),
      .last_card   (last_card),
      .not_ready   (not_ready),
      .busy        (busy),
      .sense_func  (sense_func),
      .test_func   (test_func),
      .sense_word  (sense_word),
      .test_hit    (test_hit),
      .ovr_sticky  (ovr_sticky)
   );
endmodule

// File: rtl/cardxfer_chk.sv
module cardxfer_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_valid,
   input logic          load_valid,
   input logic          busy,
   input logic          mech_go,
   input logic          mem_req,
   input logic          mem_ack,
   input logic [AW-1:0] mem_addr,
   input logic          ovr_sticky
);
   // R3
   go_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mech_go |-> busy);

   // R12
   busy_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_valid) |=> !mech_go);

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !load_valid) |=> (mem_req && $stable(mem_addr)));

   // R13
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   // R9
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_sticky && !start_valid) |=> ovr_sticky);
endmodule

bind cardxfer_ctrl cardxfer_chk #(.AW(AW)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_valid (start_valid),
   .load_valid  (load_valid),
   .busy        (busy),
   .mech_go     (mech_go),
   .mem_req     (mem_req),
   .mem_ack     (mem_ack),
   .mem_addr    (mem_addr),
   .ovr_sticky  (ovr_sticky)
);

// File: tb/test_cardxfer_ctrl.sv
module test_cardxfer_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int COLS = 80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_valid = 1'b0;
   logic [2:0]  start_func = 3'd0;
   logic [7:0]  start_ctl = 8'h00;
   logic        load_valid = 1'b0;
   logic [2:0]  load_func = 3'd0;
   logic [15:0] load_data = 16'h0000;
   logic [2:0]  sense_func = 3'd3;
   logic [15:0] sense_word;
   logic [2:0]  test_func = 3'd0;
   logic        test_hit;
   logic        busy;
   logic        mem_req;
   logic        mem_we;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        mem_ack = 1'b0;
   logic [7:0]  mem_rdata = 8'h00;
   logic        deck_present = 1'b1;
   logic        punch_ready = 1'b1;
   logic        last_card = 1'b0;
   logic        mech_go;
   logic [2:0]  mech_func;
   logic        mech_stacker;
   logic        col_tick = 1'b0;
   logic [7:0]  col_rdata = 8'h00;
   logic [7:0]  col_pdata;
   logic        col_pvalid;
   logic        mech_done = 1'b0;
   logic        read_check = 1'b0;
   logic        punch_check = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [7:0]  mem [0:255];
   logic [15:0] wlog_a [0:255];
   logic [7:0]  wlog_d [0:255];
   logic [7:0]  plog [0:255];
   logic [7:0]  cdata [0:COLS-1];
   int wn = 0;
   int pn = 0;
   int reqs = 0;
   int lat = 0;
   bit stall = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cardxfer_ctrl i_cardxfer_ctrl (
      .clk(clk), .rst_n(rst_n),
      .start_valid(start_valid), .start_func(start_func), .start_ctl(start_ctl),
      .load_valid(load_valid), .load_func(load_func), .load_data(load_data),
      .sense_func(sense_func), .sense_word(sense_word),
      .test_func(test_func), .test_hit(test_hit), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .deck_present(deck_present), .punch_ready(punch_ready), .last_card(last_card),
      .mech_go(mech_go), .mech_func(mech_func), .mech_stacker(mech_stacker),
      .col_tick(col_tick), .col_rdata(col_rdata), .col_pdata(col_pdata), .col_pvalid(col_pvalid),
      .mech_done(mech_done), .read_check(read_check), .punch_check(punch_check)
   );

   // memory model: answers after a random 0..3 cycle wait, logs writes
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (mem_req && !stall) begin
         if (lat > 0) begin
            lat = lat - 1;
         end else begin
            mem_ack = 1'b1;
            reqs = reqs + 1;
            if (mem_we) begin
               if (wn < 256) begin
                  wlog_a[wn] = mem_addr;
                  wlog_d[wn] = mem_wdata;
               end
               wn = wn + 1;
            end else begin
               mem_rdata = mem[mem_addr[7:0]];
            end
            lat = $urandom_range(0, 3);
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic do_load(input logic [2:0] f, input logic [15:0] d);
      @(negedge clk);
      load_valid = 1'b1; load_func = f; load_data = d;
      @(negedge clk);
      load_valid = 1'b0;
   endtask

   task automatic do_start(input logic [2:0] f, input logic [7:0] c);
      @(negedge clk);
      start_valid = 1'b1; start_func = f; start_ctl = c;
      @(negedge clk);
      start_valid = 1'b0;
   endtask

   task automatic col(input logic [7:0] b, input int gap);
      @(negedge clk);
      col_tick = 1'b1; col_rdata = b;
      #1;
      if (col_pvalid) begin
         if (pn < 256) plog[pn] = col_pdata;
         pn++;
      end
      @(negedge clk);
      col_tick = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic finish_card();
      @(negedge clk);
      mech_done = 1'b1;
      @(negedge clk);
      mech_done = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic run_card(input int first, input int gap);
      repeat (8) @(negedge clk);
      for (int i = first; i < COLS; i++) col(cdata[i], gap);
      finish_card();
   endtask

   function automatic int min80(input int n);
      return (n < COLS) ? n : COLS;
   endfunction

   task automatic sense_status(output logic [15:0] w);
      @(negedge clk);
      sense_func = 3'd3;
      #1 w = sense_word;
   endtask

   task automatic fill_cards();
      for (int i = 0; i < COLS; i++) cdata[i] = 8'($urandom_range(0, 255));
   endtask

   task automatic check_reads(input string tag, input int n, input logic [15:0] a, input bit blank);
      chk({tag, " write count"}, wn, n);
      for (int i = 0; i < n && i < 256; i++) begin
         chk({tag, " write addr"}, wlog_a[i], a + 16'(i));
         chk({tag, " write data"}, wlog_d[i], blank ? 8'h40 : cdata[i]);
      end
   endtask

   task automatic check_punch(input string tag, input int n, input logic [15:0] a);
      chk({tag, " punch count"}, pn, n);
      for (int i = 0; i < n && i < 256; i++) begin
         chk({tag, " punch data"}, plog[i], mem[8'(a + 16'(i))]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] w;
      logic [15:0] a;
      int n;
      void'($urandom(32'h5eed_0042));
      for (int i = 0; i < 256; i++) mem[i] = 8'($urandom_range(0, 255));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 mem_req", mem_req, 0);
      chk("R1 mech_go", mech_go, 0);
      sense_status(w);
      chk("R1 status", w, 16'h0000);

      // R10/R11/R12 not ready
      deck_present = 1'b0; punch_ready = 1'b0;
      sense_status(w);
      chk("R10 not ready bit", w, 16'h0800);
      test_func = 3'd0; #1 chk("R11 test0 not ready", test_hit, 1);
      test_func = 3'd2; #1 chk("R11 test2 idle", test_hit, 0);
      do_start(3'd1, 8'h00);
      chk("R12 start while not ready", busy, 0);
      deck_present = 1'b1;
      do_start(3'd2, 8'h00);
      chk("R12 punch without punch ready", busy, 0);
      punch_ready = 1'b1;
      do_start(3'd5, 8'h00);
      chk("R12 function 5", busy, 0);

      // R2/R3/R4/R5 directed read, count 5
      fill_cards();
      do_load(3'd0, 16'd5);
      do_load(3'd4, 16'h0100);
      wn = 0;
      do_start(3'd1, 8'h01);
      chk("R3 mech_go", mech_go, 1);
      chk("R3 mech_func", mech_func, 3'd1);
      chk("R3 stacker", mech_stacker, 1);
      chk("R3 busy", busy, 1);
      test_func = 3'd2; #1 chk("R11 test2 busy", test_hit, 1);
      test_func = 3'd0; #1 chk("R11 test0 busy", test_hit, 1);
      do_start(3'd0, 8'h00);
      chk("R12 start while busy", mech_go, 0);
      run_card(0, 6);
      chk("R13 busy falls", busy, 0);
      check_reads("R4 R2 read5", 5, 16'h0100, 0);

      // R6 no reload of address
      fill_cards();
      do_load(3'd0, 16'd3);
      wn = 0;
      do_start(3'd3, 8'h00);
      chk("R3 mech_func bin", mech_func, 3'd3);
      chk("R3 stacker normal", mech_stacker, 0);
      run_card(0, 6);
      check_reads("R6 continue", 3, 16'h0105, 0);

      // R5 long count capped at 80
      fill_cards();
      do_load(3'd0, 16'd200);
      do_load(3'd4, 16'h0020);
      wn = 0;
      do_start(3'd1, 8'h00);
      run_card(0, 6);
      check_reads("R5 cap80", 80, 16'h0020, 0);

      // R5 zero count
      fill_cards();
      do_load(3'd0, 16'd0);
      wn = 0;
      do_start(3'd1, 8'h00);
      run_card(0, 6);
      chk("R5 zero count writes", wn, 0);

      // R7 punch and feed
      do_load(3'd0, 16'd12);
      do_load(3'd4, 16'h0040);
      pn = 0;
      do_start(3'd2, 8'h01);
      chk("R7 mech_func punch", mech_func, 3'd2);
      run_card(0, 6);
      check_punch("R7 punch12", 12, 16'h0040);
      sense_status(w);
      chk("R9 no overrun on punch", w, 16'h0000);

      // R7 punch without feed, long count
      do_load(3'd0, 16'd90);
      do_load(3'd4, 16'h00F0);
      pn = 0;
      do_start(3'd4, 8'h00);
      chk("R7 mech_func hold", mech_func, 3'd4);
      run_card(0, 6);
      check_punch("R7 punch cap", 80, 16'h00F0);

      // R8 blank supply
      deck_present = 1'b0;
      fill_cards();
      do_load(3'd0, 16'd4);
      do_load(3'd4, 16'h0200);
      wn = 0;
      do_start(3'd1, 8'h00);
      chk("R8 blank read accepted", busy, 1);
      run_card(0, 6);
      check_reads("R8 blank", 4, 16'h0200, 1);
      deck_present = 1'b1;

      // R13 feed: no memory traffic
      do_load(3'd0, 16'd10);
      reqs = 0;
      do_start(3'd0, 8'h00);
      chk("R13 feed busy", busy, 1);
      run_card(0, 6);
      chk("R13 feed no requests", reqs, 0);
      chk("R13 feed busy falls", busy, 0);

      // R9 overrun on read
      fill_cards();
      do_load(3'd0, 16'd10);
      do_load(3'd4, 16'h0300);
      stall = 1;
      do_start(3'd1, 8'h00);
      repeat (4) @(negedge clk);
      col(cdata[0], 2);
      col(cdata[1], 2);
      sense_status(w);
      chk("R9 overrun set", w & 16'h1000, 16'h1000);
      stall = 0;
      for (int i = 2; i < COLS; i++) col(cdata[i], 6);
      finish_card();
      sense_status(w);
      chk("R9 overrun held", w & 16'h1000, 16'h1000);
      do_start(3'd0, 8'h00);
      sense_status(w);
      chk("R9 overrun cleared by start", w & 16'h1000, 16'h0000);
      finish_card();

      // R10 sticky checks and last card
      last_card = 1'b1;
      sense_status(w);
      chk("R10 last card", w, 16'h4000);
      last_card = 1'b0;
      @(negedge clk); read_check = 1'b1; @(negedge clk); read_check = 1'b0;
      sense_status(w);
      chk("R10 read check", w, 16'h8000);
      @(negedge clk); punch_check = 1'b1; @(negedge clk); punch_check = 1'b0;
      sense_status(w);
      chk("R10 punch check", w, 16'hA000);
      @(negedge clk); sense_func = 3'd1; #1 chk("R10 other sense", sense_word, 16'h0000);
      do_start(3'd0, 8'h00);
      sense_status(w);
      chk("R10 checks cleared", w, 16'h0000);
      finish_card();

      // random mix of reads and punches
      for (int it = 0; it < 6; it++) begin
         bit pun;
         logic [7:0] ctl;
         n = $urandom_range(0, 99);
         a = 16'($urandom_range(0, 65535));
         pun = 1'($urandom_range(0, 1));
         ctl = 8'($urandom_range(0, 1));
         fill_cards();
         for (int i = 0; i < 256; i++) mem[i] = 8'($urandom_range(0, 255));
         do_load(3'd0, 16'(n));
         do_load(3'd4, a);
         wn = 0; pn = 0;
         do_start(pun ? 3'd2 : 3'd1, ctl);
         chk("R3 random stacker", mech_stacker, ctl[0]);
         run_card(0, 6);
         if (pun) check_punch("R7 random", min80(n), a);
         else check_reads("R4 random", min80(n), a, 0);
      end

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule